// File: doc/BRIEF.md
# Gray-Scale Pulse Phase Generator

This block turns a stored gray level for each display column into a timed drive sequence. A frame lasts 128 count-clock cycles. During a frame every column first holds the negative rail and then drives the positive rail for a pulse of fixed length, 64 cycles. After the pulse it goes back to the negative rail until the frame is over. The gray level sets only where the pulse starts. Between frames every column rests at the ground level.

All columns share one frame counter. Each column latches its 6-bit level when a frame starts and compares the shared count against that level to pick a 2-bit switch-select code. The code is registered, so it changes only on clock edges. A one-cycle done flag marks the end of each frame. A new start request can arrive in the last cycle of a frame, and the next frame then follows with no rest cycle in between.

Top module: `gs_phase_gen`

## Requirements
- R1: After reset every column outputs the rest code and the done flag is low.
- R2: A start request seen at a clock edge while idle begins a frame. The frame's cycle k=0 is the cycle right after that edge, and the frame covers cycles k=0..127.
- R3: A column with latched level d outputs the negative code (01) in frame cycles 0..d, which is d+1 cycles.
- R4: The same column then outputs the positive code (10) for exactly 64 cycles, frame cycles d+1..d+64.
- R5: For the remaining frame cycles, d+65..127, the column outputs the negative code (01) again.
- R6: Outside a frame, every column outputs the rest code (00) until the next accepted start.
- R7: The done flag is high for exactly one cycle, the cycle that follows frame cycle 127.
- R8: Code values are 00 rest, 01 negative, 10 positive. The code 11 never appears.
- R9: Each column's level is latched at the edge that accepts a start. Changes on the level inputs during a frame have no effect on that frame.
- R10: A start request during frame cycles 0..126 is ignored, and the running frame continues unchanged.
- R11: A start request during frame cycle 127 begins a new frame at once, with newly latched levels. The done flag is still raised in that new frame's cycle 0.
- R12: Columns are independent: each column's sequence depends only on its own latched level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request |
| level_i | input | NUM_COLS*6 | Packed gray levels, column c at bits [6c+5:6c] |
| drive_o | output | NUM_COLS*2 | Packed drive codes, column c at bits [2c+1:2c] |
| done_o | output | 1 | One-cycle end-of-frame flag |

## Verification
The end-of-frame flag and the acceptance of a new start can fall in the same cycle. The bench raises a start request, with a fresh set of levels, during frame cycle 127. It then checks two things in the next cycle: the done flag is high, and every column already shows cycle 0 of the new frame for its new level. It also checks the full new frame that follows. Separately, starts raised in the middle of a frame and level changes made during a frame are checked against an unchanged expected sequence.

// File: rtl/gs_phase_pkg.sv
package gs_phase_pkg;

    localparam int unsigned GS_LEVEL_W = 6;
    localparam int unsigned GS_COLS    = 8;

    typedef enum logic [1:0] {
        DRV_REST = 2'b00,
        DRV_NEG  = 2'b01,
        DRV_POS  = 2'b10
    } drive_e;

endpackage

// File: rtl/gs_frame_counter.sv
module gs_frame_counter #(
    parameter int unsigned LEVEL_W = gs_phase_pkg::GS_LEVEL_W,
    localparam int unsigned CNT_W  = LEVEL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             accept_o,
    output logic             nxt_active_o,
    output logic [CNT_W-1:0] nxt_cnt_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             last_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign last_o       = busy_o && (cnt_o == CNT_MAX);
    assign accept_o     = start_i && (!busy_o || last_o);
    assign nxt_active_o = accept_o || (busy_o && !last_o);
    assign nxt_cnt_o    = accept_o ? '0 : cnt_o + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            busy_o <= nxt_active_o;
            cnt_o  <= nxt_active_o ? nxt_cnt_o : '0;
            done_o <= last_o;
        end
    end

endmodule

// File: rtl/gs_column_cell.sv
module gs_column_cell #(
    parameter int unsigned LEVEL_W = gs_phase_pkg::GS_LEVEL_W,
    localparam int unsigned CNT_W  = LEVEL_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept_i,
    input  logic               nxt_active_i,
    input  logic [CNT_W-1:0]   nxt_cnt_i,
    input  logic [LEVEL_W-1:0] level_i,
    output gs_phase_pkg::drive_e drive_o
);
    import gs_phase_pkg::*;

    localparam logic [CNT_W:0] PULSE_LEN = (CNT_W+1)'(1) << LEVEL_W;

    logic [LEVEL_W-1:0] level_q;
    logic [LEVEL_W-1:0] level_use;
    logic [CNT_W:0]     k_ext;
    logic [CNT_W:0]     d_ext;
    drive_e             code_nxt;

    assign level_use = accept_i ? level_i : level_q;
    assign k_ext     = {1'b0, nxt_cnt_i};
    assign d_ext     = {2'b00, level_use};

    always_comb begin
        if (!nxt_active_i)
            code_nxt = DRV_REST;
        else if (k_ext <= d_ext)
            code_nxt = DRV_NEG;
        else if (k_ext <= d_ext + PULSE_LEN)
            code_nxt = DRV_POS;
        else
            code_nxt = DRV_NEG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            drive_o <= DRV_REST;
        end else begin
            if (accept_i)
                level_q <= level_i;
            drive_o <= code_nxt;
        end
    end

endmodule

// File: rtl/gs_phase_gen.sv
module gs_phase_gen #(
    parameter int unsigned NUM_COLS = gs_phase_pkg::GS_COLS,
    parameter int unsigned LEVEL_W  = gs_phase_pkg::GS_LEVEL_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [NUM_COLS*LEVEL_W-1:0] level_i,
    output logic [NUM_COLS*2-1:0]       drive_o,
    output logic                        done_o
);
    import gs_phase_pkg::*;

    localparam int unsigned CNT_W = LEVEL_W + 1;

    logic             accept;
    logic             nxt_active;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             last;

    gs_frame_counter #(.LEVEL_W(LEVEL_W)) cnt_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .accept_o     (accept),
        .nxt_active_o (nxt_active),
        .nxt_cnt_o    (nxt_cnt),
        .cnt_o        (cnt),
        .busy_o       (busy),
        .last_o       (last),
        .done_o       (done_o)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        drive_e code;
        gs_column_cell #(.LEVEL_W(LEVEL_W)) cell_i (
            .clk          (clk),
            .rst          (rst),
            .accept_i     (accept),
            .nxt_active_i (nxt_active),
            .nxt_cnt_i    (nxt_cnt),
            .level_i      (level_i[c*LEVEL_W +: LEVEL_W]),
            .drive_o      (code)
        );
        assign drive_o[c*2 +: 2] = code;
    end

endmodule

// File: rtl/gs_phase_chk.sv
module gs_phase_chk #(
    parameter int unsigned NUM_COLS = 8,
    parameter int unsigned CNT_W    = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  done_o,
    input logic [NUM_COLS*2-1:0] drive_o,
    input logic                  busy,
    input logic                  last,
    input logic [CNT_W-1:0]      cnt
);

    logic any_illegal;
    logic all_rest;
    logic col0_neg;

    always_comb begin
        any_illegal = 1'b0;
        for (int c = 0; c < NUM_COLS; c++)
            if (drive_o[c*2 +: 2] == 2'b11) any_illegal = 1'b1;
    end
    assign all_rest = (drive_o == '0);
    assign col0_neg = (drive_o[1:0] == 2'b01);

    // R8: the unused code never leaves the block
    p_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
        !any_illegal);

    // R6: every column rests while no frame runs
    p_idle_rest_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> all_rest);

    // R7: done follows the last frame cycle and only it
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        last |=> done_o);
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2 / R3: an accepted start opens a frame whose first cycle drives negative
    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy) |=> (busy && cnt == '0 && col0_neg));

    // R10: mid-frame start does not disturb the count
    p_mid_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R11: start in the last cycle restarts at once
    p_back_to_back_r11: assert property (@(posedge clk) disable iff (rst)
        (start_i && last) |=> (busy && cnt == '0 && done_o));

endmodule

bind gs_phase_gen gs_phase_chk #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .drive_o (drive_o),
    .busy    (busy),
    .last    (last),
    .cnt     (cnt)
);

// File: tb/gs_phase_gen_tb.sv
module gs_phase_gen_tb_top;

    localparam int NC = 8;
    localparam int LW = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [NC*LW-1:0] level_i = '0;
    logic [NC*2-1:0]  drive_o;
    logic             done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gs_phase_gen #(.NUM_COLS(NC), .LEVEL_W(LW)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .level_i (level_i),
        .drive_o (drive_o),
        .done_o  (done_o)
    );

    function automatic logic [1:0] exp_code(int k, int d);
        if (k <= d)           return 2'b01;
        else if (k <= d + 64) return 2'b10;
        else                  return 2'b01;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // checks one frame cycle for every column against the latched levels
    task automatic chk_cycle(int k, int lv[NC], string req);
        for (int c = 0; c < NC; c++)
            chk(req, {6'd0, drive_o[c*2 +: 2]}, {6'd0, exp_code(k, lv[c])});
    endtask

    task automatic chk_rest(string req);
        for (int c = 0; c < NC; c++)
            chk(req, {6'd0, drive_o[c*2 +: 2]}, 8'd0);
    endtask

    // runs one frame; optional level change and mid-frame start, optional chained start
    task automatic run_frame(int lv[NC], bit disturb, bit chain, int nxt[NC]);
        for (int k = 0; k < 128; k++) begin
            if (k <= lv[0]) chk_cycle(k, lv, "R3");
            else if (k <= lv[0] + 64) chk_cycle(k, lv, "R4");
            else chk_cycle(k, lv, "R5");
            if (k != 0) chk("R7", {7'd0, done_o}, 8'd0);
            start_i = 1'b0;
            if (disturb && k == 10) begin
                for (int c = 0; c < NC; c++) level_i[c*LW +: LW] = LW'(63 - lv[c]);
                start_i = 1'b1;
            end
            if (disturb && (k == 11 || k == 126)) start_i = 1'b1;
            if (chain && k == 127) begin
                for (int c = 0; c < NC; c++) level_i[c*LW +: LW] = LW'(nxt[c]);
                start_i = 1'b1;
            end
            tick();
        end
        start_i = 1'b0;
        chk(chain ? "R11" : "R7", {7'd0, done_o}, 8'd1);
    endtask

    task automatic launch(int lv[NC]);
        for (int c = 0; c < NC; c++) level_i[c*LW +: LW] = LW'(lv[c]);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int lv[NC];
        int nx[NC];
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk_rest("R1");
        chk("R1", {7'd0, done_o}, 8'd0);

        // sweep all 64 levels, columns each on a different level (R12)
        for (int f = 0; f < 8; f++) begin
            for (int c = 0; c < NC; c++) lv[c] = (f * 8 + c * 9) % 64;
            launch(lv);
            chk_cycle(0, lv, "R2");
            run_frame(lv, 1'b0, 1'b0, nx);
            chk_rest("R6");
            tick();
            chk("R7", {7'd0, done_o}, 8'd0);
            chk_rest("R6");
            repeat (3) tick();
            chk_rest("R6");
        end

        // level changes and starts during a frame (R9, R10)
        for (int c = 0; c < NC; c++) lv[c] = c * 7 + 3;
        launch(lv);
        run_frame(lv, 1'b1, 1'b0, nx);
        chk_rest("R10");
        tick();

        // back-to-back frames with start in cycle 127 (R11)
        for (int c = 0; c < NC; c++) begin
            lv[c] = 63 - c;
            nx[c] = c;
        end
        launch(lv);
        run_frame(lv, 1'b0, 1'b1, nx);
        chk_cycle(0, nx, "R11");
        for (int c = 0; c < NC; c++) lv[c] = nx[c];
        for (int c = 0; c < NC; c++) nx[c] = 0;
        run_frame(lv, 1'b0, 1'b0, nx);
        chk_rest("R6");

        // extremes on every column
        for (int c = 0; c < NC; c++) lv[c] = (c % 2 == 0) ? 0 : 63;
        launch(lv);
        run_frame(lv, 1'b0, 1'b0, nx);
        chk_rest("R6");

        // reset mid-frame returns to rest
        launch(lv);
        repeat (20) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_rest("R1");
        chk("R1", {7'd0, done_o}, 8'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule